// File: doc/BRIEF.md
# Programmable Display Timing Generator

The block produces the raster timing for a progressive video output. A horizontal counter runs across each line and a vertical counter steps once per line. Active video, horizontal sync, vertical sync, a composite sync for a sync-on-green path and a once-per-line prefetch strobe are decoded from these counters. Each decode is compared against a programmed boundary. Every boundary is written as its pixel or line count minus one. For example, the horizontal total register holds active width + front porch + sync width + back porch - 1.

Software sets up the block through a single-cycle register write port that runs in the pixel-clock domain. While the generator is disabled, every write to a geometry, sync or blanking register goes straight into use. While it runs, such a write waits in a shadow copy until the current frame ends, so a frame never mixes two timings. The control register acts at once. It carries the run bit and the refresh bit. The sync register also provides per-sync polarity inversion and suspend modes that switch off hsync, vsync or both.

Top module: `display_timing_gen`

## Requirements
- R1: While rst_ni is low, h_cnt_o and v_cnt_o are 0, and de_o, hsync_o, vsync_o, sog_o and prefetch_o are all 0.
- R2: With run set, h_cnt_o counts 0 up to the horizontal total (address 1) and then returns to 0. v_cnt_o advances on each such return and goes back to 0 after reaching the vertical total (address 5).
- R3: Control register (address 0) bit 0 is run and bit 1 is refresh; both act on the next clock. While run is 0, both counters keep their values.
- R4: de_o is 1 exactly when all of these hold: run and refresh are set, display-off is clear, h_cnt_o is at or below horizontal display end (address 2), and v_cnt_o is at or below vertical display end (address 6).
- R5: The raw hsync level is active while run is set and h_cnt_o is greater than hsync start (address 3) and no greater than hsync end (address 4). The raw vsync level uses v_cnt_o with vsync start (address 7) and vsync end (address 8) in the same way.
- R6: In the sync register (address 10), bit 3 inverts hsync_o and bit 4 inverts vsync_o. With both bits clear, both syncs are active high.
- R7: In the sync register, bit 5 switches hsync off, bit 6 switches vsync off, and bit 1 switches both off. A switched-off sync sits at its inactive level, which is the value of its inversion bit.
- R8: When sync register bit 0 is set, sog_o is the OR of the enabled, non-inverted hsync and vsync levels. When bit 0 is clear, sog_o is 0.
- R9: Bit 0 of the blanking register (address 11) forces de_o to 0 and leaves hsync_o and vsync_o unchanged.
- R10: prefetch_o is 1 for the single pixel on each line where h_cnt_o equals the prefetch position (address 9), and only while run and refresh are set.
- R11: Writes to addresses 1 to 11 take effect at once while run is 0. While run is 1, they take effect on the cycle after the last pixel of the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Register write data |
| h_cnt_o | output | CNT_W | Pixel position in the line |
| v_cnt_o | output | CNT_W | Line position in the frame |
| de_o | output | 1 | Active video |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| sog_o | output | 1 | Composite sync for the green channel |
| prefetch_o | output | 1 | Per-line fetch request strobe |

## Verification
The hardest case to reach is a geometry change written in the middle of a running frame. The old timing has to persist up to the exact frame boundary, and the new timing has to start on the very next pixel. The stimulus writes a complete new geometry, with different totals, while the counters are partway through a line. It then runs across the boundary. A cycle-accurate bench model that keeps its own shadow and active copies predicts every output on every cycle. The suspend, polarity and blanking writes go through the same deferred path, so each one is checked at its frame edge as well.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned ADDR_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_HTOT   = 4'd1,
    A_HDISP  = 4'd2,
    A_HS_BEG = 4'd3,
    A_HS_END = 4'd4,
    A_VTOT   = 4'd5,
    A_VDISP  = 4'd6,
    A_VS_BEG = 4'd7,
    A_VS_END = 4'd8,
    A_PF     = 4'd9,
    A_SYNC   = 4'd10,
    A_BLANK  = 4'd11
  } reg_addr_e;

  typedef struct packed {
    cnt_t h_tot;
    cnt_t h_disp;
    cnt_t hs_beg;
    cnt_t hs_end;
    cnt_t v_tot;
    cnt_t v_disp;
    cnt_t vs_beg;
    cnt_t vs_end;
    cnt_t pf;
    logic sog;
    logic all_off;
    logic h_inv;
    logic v_inv;
    logic h_off;
    logic v_off;
    logic disp_off;
  } cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int unsigned ADDR_W = dtg_pkg::ADDR_W,
  parameter int unsigned DATA_W = dtg_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_end_i,
  output logic              gen_en_o,
  output logic              refresh_en_o,
  output cfg_t              act_o
);
  cfg_t       sh_q;
  logic [1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:   ctrl_q      <= wr_data_i[1:0];
        A_HTOT:   sh_q.h_tot  <= wr_data_i[CNT_W-1:0];
        A_HDISP:  sh_q.h_disp <= wr_data_i[CNT_W-1:0];
        A_HS_BEG: sh_q.hs_beg <= wr_data_i[CNT_W-1:0];
        A_HS_END: sh_q.hs_end <= wr_data_i[CNT_W-1:0];
        A_VTOT:   sh_q.v_tot  <= wr_data_i[CNT_W-1:0];
        A_VDISP:  sh_q.v_disp <= wr_data_i[CNT_W-1:0];
        A_VS_BEG: sh_q.vs_beg <= wr_data_i[CNT_W-1:0];
        A_VS_END: sh_q.vs_end <= wr_data_i[CNT_W-1:0];
        A_PF:     sh_q.pf     <= wr_data_i[CNT_W-1:0];
        A_SYNC: begin
          sh_q.sog     <= wr_data_i[0];
          sh_q.all_off <= wr_data_i[1];
          sh_q.h_inv   <= wr_data_i[3];
          sh_q.v_inv   <= wr_data_i[4];
          sh_q.h_off   <= wr_data_i[5];
          sh_q.v_off   <= wr_data_i[6];
        end
        A_BLANK:  sh_q.disp_off <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // shadow copy moves into use only between frames or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      act_o <= '0;
    else if (!ctrl_q[0] || frame_end_i) act_o <= sh_q;
  end

  assign gen_en_o     = ctrl_q[0];
  assign refresh_en_o = ctrl_q[1];

  AST_CFG_FROZEN_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_en_o && !frame_end_i) |=> $stable(act_o)); // R11
endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_o)); // R3
  AST_CNT_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0)); // R2
endmodule

// File: rtl/dtg_sync.sv
module dtg_sync
  import dtg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_en_i,
  input  logic refresh_en_i,
  input  cfg_t cfg_i,
  input  cnt_t h_cnt_i,
  input  cnt_t v_cnt_i,
  output logic de_o,
  output logic hsync_o,
  output logic vsync_o,
  output logic sog_o,
  output logic prefetch_o
);
  logic h_vis, v_vis, h_raw, v_raw, h_lvl, v_lvl, scan_on;

  assign scan_on = gen_en_i && refresh_en_i;
  assign h_vis   = h_cnt_i <= cfg_i.h_disp;
  assign v_vis   = v_cnt_i <= cfg_i.v_disp;
  assign de_o    = scan_on && !cfg_i.disp_off && h_vis && v_vis;

  assign h_raw = gen_en_i && (h_cnt_i > cfg_i.hs_beg) && (h_cnt_i <= cfg_i.hs_end);
  assign v_raw = gen_en_i && (v_cnt_i > cfg_i.vs_beg) && (v_cnt_i <= cfg_i.vs_end);

  assign h_lvl = h_raw && !cfg_i.all_off && !cfg_i.h_off;
  assign v_lvl = v_raw && !cfg_i.all_off && !cfg_i.v_off;

  assign hsync_o    = h_lvl ^ cfg_i.h_inv;
  assign vsync_o    = v_lvl ^ cfg_i.v_inv;
  assign sog_o      = cfg_i.sog && (h_lvl || v_lvl);
  assign prefetch_o = scan_on && (h_cnt_i == cfg_i.pf);

  AST_HSYNC_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.all_off || cfg_i.h_off) |-> (hsync_o == cfg_i.h_inv)); // R7
  AST_VSYNC_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.all_off || cfg_i.v_off) |-> (vsync_o == cfg_i.v_inv)); // R7
  AST_BLANK_NO_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.disp_off |-> !de_o); // R9
  AST_SOG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.sog |-> !sog_o); // R8
endmodule

// File: rtl/display_timing_gen.sv
module display_timing_gen
  import dtg_pkg::*;
#(
  parameter int unsigned ADDR_W = dtg_pkg::ADDR_W,
  parameter int unsigned DATA_W = dtg_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  h_cnt_o,
  output logic [CNT_W-1:0]  v_cnt_o,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              sog_o,
  output logic              prefetch_o
);
  cfg_t act;
  logic gen_en, refresh_en, h_wrap, v_wrap, frame_end;

  assign frame_end = h_wrap && v_wrap;

  dtg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .gen_en_o    (gen_en),
    .refresh_en_o(refresh_en),
    .act_o       (act)
  );

  dtg_counter #(.W(CNT_W)) u_hcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(gen_en),
    .last_i(act.h_tot),
    .cnt_o (h_cnt_o),
    .wrap_o(h_wrap)
  );

  dtg_counter #(.W(CNT_W)) u_vcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(h_wrap),
    .last_i(act.v_tot),
    .cnt_o (v_cnt_o),
    .wrap_o(v_wrap)
  );

  dtg_sync u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_en_i    (gen_en),
    .refresh_en_i(refresh_en),
    .cfg_i       (act),
    .h_cnt_i     (h_cnt_o),
    .v_cnt_i     (v_cnt_o),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .sog_o       (sog_o),
    .prefetch_o  (prefetch_o)
  );

  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (h_cnt_o == '0 && v_cnt_o == '0)); // R2
  AST_PF_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_o |-> (gen_en && refresh_en)); // R10
endmodule

// File: tb/display_timing_gen_test.sv
module display_timing_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic [11:0] h_cnt_o, v_cnt_o;
  logic        de_o, hsync_o, vsync_o, sog_o, prefetch_o;

  int tests = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  display_timing_gen uut (.*);

  typedef struct { int hc; int vc; bit de; bit hs; bit vs; bit sog; bit pf; } exp_t;
  exp_t q[$];

  // bench model state
  bit [1:0] m_ctrl;
  int sh[16];
  int act[16];
  int m_h, m_v;

  task automatic chk(string tag, int act_v, int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic exp_t predict();
    exp_t e;
    bit en, rf, hr, vr, hl, vl;
    int sc;
    en = m_ctrl[0]; rf = m_ctrl[1]; sc = act[10];
    e.hc = m_h; e.vc = m_v;
    e.de = en && rf && !act[11][0] && m_h <= act[2] && m_v <= act[6];
    hr = en && m_h > act[3] && m_h <= act[4];
    vr = en && m_v > act[7] && m_v <= act[8];
    hl = hr && !sc[1] && !sc[5];
    vl = vr && !sc[1] && !sc[6];
    e.hs = hl ^ sc[3];
    e.vs = vl ^ sc[4];
    e.sog = sc[0] && (hl || vl);
    e.pf = en && rf && m_h == act[9];
    return e;
  endfunction

  // driver side: advance the model on each edge and queue the expected outputs
  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit en, hw, fe;
      en = m_ctrl[0];
      hw = en && m_h >= act[1];
      fe = hw && m_v >= act[5];
      if (en) m_h = hw ? 0 : m_h + 1;
      if (hw) m_v = (m_v >= act[5]) ? 0 : m_v + 1;
      if (!en || fe) act = sh; // R11 deferred load
      if (wr_en_i) begin
        if (wr_addr_i == 0) m_ctrl = wr_data_i[1:0];
        else sh[wr_addr_i] = int'(wr_data_i);
      end
      q.push_back(predict());
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2/R3 h_cnt", int'(h_cnt_o), e.hc);
      chk("R2/R3 v_cnt", int'(v_cnt_o), e.vc);
      chk("R4/R9/R11 de", int'(de_o), int'(e.de));
      chk("R5/R6/R7/R11 hsync", int'(hsync_o), int'(e.hs));
      chk("R5/R6/R7/R11 vsync", int'(vsync_o), int'(e.vs));
      chk("R8 sog", int'(sog_o), int'(e.sog));
      chk("R10 prefetch", int'(prefetch_o), int'(e.pf));
    end
  end

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 12'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_ctrl = '0; m_h = 0; m_v = 0;
    for (int i = 0; i < 16; i++) begin sh[i] = 0; act[i] = 0; end
    run(3);
    // R1 reset state
    chk("R1 h_cnt", int'(h_cnt_o), 0);
    chk("R1 v_cnt", int'(v_cnt_o), 0);
    chk("R1 de", int'(de_o), 0);
    chk("R1 hsync", int'(hsync_o), 0);
    chk("R1 vsync", int'(vsync_o), 0);
    chk("R1 sog", int'(sog_o), 0);
    chk("R1 prefetch", int'(prefetch_o), 0);
    rst_ni = 1'b1;
    run(1);
    // geometry programmed while stopped: 10 px x 6 lines
    wr(1, 9); wr(2, 5); wr(3, 6); wr(4, 7); wr(9, 8);
    wr(5, 5); wr(6, 3); wr(7, 3); wr(8, 4);
    wr(10, 0); wr(11, 0);
    wr(0, 3);
    run(130);
    // mid-frame geometry change (R11)
    run(7);
    wr(1, 11); wr(2, 7); wr(3, 8); wr(4, 10); wr(9, 10);
    wr(5, 4); wr(6, 2); wr(7, 2); wr(8, 3);
    run(150);
    // polarity, suspend and composite sync modes
    wr(10, 'h18); run(70);
    wr(10, 'h20); run(70);
    wr(10, 'h40); run(70);
    wr(10, 'h02); run(70);
    wr(10, 'h01); run(70);
    wr(10, 'h39); run(70);
    wr(10, 'h00); run(10);
    // display off, then restore
    wr(11, 1); run(70);
    wr(11, 0); run(70);
    // refresh off, then stop and hold, then restart
    wr(0, 1); run(40);
    wr(0, 0); run(25);
    wr(1, 6); run(5);
    wr(0, 3); run(90);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule